// File: doc/BRIEF.md
# Quarter-Wave Sine Sample Generator

This block produces a stream of signed 14-bit sine samples for a DAC, one per clock. A 32-bit phase accumulator adds a programmable tuning word on every clock. Its top two bits name the quadrant and the next eleven bits index a table that holds only the rising quarter of the sine, from zero up to the peak. The full cycle of 8192 effective points is rebuilt from that quarter in two ways. The table address runs backwards in the falling quadrants. A sign stage makes the samples negative in the second half of the cycle.

The negative half can be formed in two ways, chosen by a mode input. Plain bitwise inversion is cheap, but it maps a zero sample to -1 and shifts the whole negative half down by one step. Full two's-complement negation adds one after the inversion and keeps zero at zero. Both modes pass through the same three register stages, so the data and the sign information never drift apart. A one-clock sync flag travels with the first sample of each new cycle. The quarter table is computed from a sine function when the design is elaborated.

Top module: `sine_quarter_gen`

## Requirements
- R1: Each clock not in reset, the phase accumulator adds the tuning word modulo 2^32. Phase bits 31:30 form the quadrant number and bits 29:19 form the 11-bit table index.
- R2: The quarter table has 2048 entries. Entry a holds round(8191 * sin(pi * a / 4096)), so entry 0 is 0 and entry 2047 is 8191. Output samples therefore lie within -8192..8191.
- R3: In quadrants 0 and 2 the table address equals the index. In quadrants 1 and 3 it equals 2047 minus the index, which is the bitwise complement of the index.
- R4: In quadrants 0 and 1 (phase bit 31 clear) the sample equals the table value and is never negative. In quadrants 2 and 3 it is the negative form of the table value.
- R5: With negMode = 1, a negative-half sample is the two's-complement negation of the table value. A zero table value gives 0, never -1, and no sample is -8192.
- R6: With negMode = 0, a negative-half sample is the bitwise inversion of the table value, which equals minus the value minus 1. A zero table value gives -1.
- R7: A phase held in the accumulator appears at the sample output three clocks later, in both modes. negMode takes effect in the second of those stages.
- R8: cycleSync is high for one clock, together with the sample whose phase came from a carry out of the accumulator addition.
- R9: A synchronous active-high reset clears the accumulator and every pipeline stage. After a reset edge the output is 0 with cycleSync low. After release, the first three samples are 0, and then the sample of phase equal to the tuning word follows.
- R10: With a tuning word of 0 and a steady negMode, the output holds a constant value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tuningWord | input | 32 | Phase increment added each clock |
| negMode | input | 1 | 0: invert for the negative half; 1: two's-complement negate |
| sample | output | 14 | Signed sine sample for the DAC |
| cycleSync | output | 1 | One-clock flag on the first sample of each cycle |

## Verification
The checker examines four properties on every cycle. The output is cleared after a reset edge. The sample is non-negative whenever the phase three clocks earlier was in the positive half. In two's-complement mode, neither -1 nor -8192 ever appears. After several idle clocks with a zero tuning word, the output stays still. Other behaviour needs the bench's scenarios to show it. These are the exact waveform values: the address reversal at the peak, the differing zero-crossing codes of the two modes, the reached extremes 8191 and -8191/-8192, the exact three-clock latency, and the alignment of the sync flag with wrapping phases, including tuning words large enough to wrap on consecutive clocks.

// File: rtl/sine_pkg.sv
package sine_pkg;
  // Strobes passed from phase control to the sample datapath.
  typedef struct packed {
    logic negate;      // phase lies in the negative half
    logic cycleStart;  // phase came from an accumulator carry
  } strobe_t;

  // Rounded quarter-sine value for table entry idx.
  function automatic int quarterValue(input int idx, input int depth, input int peak);
    real angle;
    angle = 3.14159265358979323846 * real'(idx) / (2.0 * real'(depth));
    return $rtoi(real'(peak) * $sin(angle) + 0.5);
  endfunction
endpackage

// File: rtl/sine_ctl.sv
module sine_ctl #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PHASE_W-1:0]   tuningWord,
  output logic [ADDR_W-1:0]    romAddr,
  output sine_pkg::strobe_t    strobe
);
  localparam int QUAD_HI = PHASE_W - 1;
  localparam int IDX_HI  = PHASE_W - 3;

  logic [PHASE_W-1:0] phaseAcc;
  logic               wrapFlag;
  logic [PHASE_W:0]   phaseSum;
  logic [1:0]         quadrant;
  logic [ADDR_W-1:0]  quarterIdx;

  assign phaseSum = {1'b0, phaseAcc} + {1'b0, tuningWord};

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      wrapFlag <= 1'b0;
    end else begin
      phaseAcc <= phaseSum[PHASE_W-1:0];
      wrapFlag <= phaseSum[PHASE_W];
    end
  end

  assign quadrant   = phaseAcc[QUAD_HI -: 2];
  assign quarterIdx = phaseAcc[IDX_HI -: ADDR_W];

  // Odd quadrants walk the table backwards.
  assign romAddr = quadrant[0] ? ~quarterIdx : quarterIdx;

  assign strobe.negate     = quadrant[1];
  assign strobe.cycleStart = wrapFlag;
endmodule

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int ADDR_W = 11,
  parameter int MAG_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tableWord [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam int Value = sine_pkg::quarterValue(g, DEPTH, PEAK);
    assign tableWord[g] = MAG_W'(Value);
  end

  always_ff @(posedge clk) begin
    if (rst) mag <= '0;
    else     mag <= tableWord[addr];
  end
endmodule

// File: rtl/sine_datapath.sv
module sine_datapath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     negMode,
  input  logic [ADDR_W-1:0]        romAddr,
  input  sine_pkg::strobe_t        strobe,
  output logic signed [DATA_W-1:0] sample,
  output logic                     cycleSync
);
  localparam int MAG_W = DATA_W - 1;

  // Stage 1: table read, strobes follow.
  logic [MAG_W-1:0]  romMag;
  sine_pkg::strobe_t s1Strobe;

  sine_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) uRom (
    .clk (clk),
    .rst (rst),
    .addr(romAddr),
    .mag (romMag)
  );

  always_ff @(posedge clk) begin
    if (rst) s1Strobe <= '0;
    else     s1Strobe <= strobe;
  end

  // Stage 2: conditional inversion, carry-in held apart.
  logic [DATA_W-1:0] invWord;
  logic              addOne;
  logic              s2Sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      invWord <= '0;
      addOne  <= 1'b0;
      s2Sync  <= 1'b0;
    end else begin
      invWord <= s1Strobe.negate ? ~{1'b0, romMag} : {1'b0, romMag};
      addOne  <= s1Strobe.negate & negMode;
      s2Sync  <= s1Strobe.cycleStart;
    end
  end

  // Stage 3: carry propagation, same depth in both modes.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample    <= '0;
      cycleSync <= 1'b0;
    end else begin
      sample    <= invWord + DATA_W'(addOne);
      cycleSync <= s2Sync;
    end
  end
endmodule

// File: rtl/sine_quarter_gen.sv
module sine_quarter_gen #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       tuningWord,
  input  logic                     negMode,
  output logic signed [DATA_W-1:0] sample,
  output logic                     cycleSync
);
  logic [ADDR_W-1:0] romAddr;
  sine_pkg::strobe_t ctlStrobe;

  sine_ctl #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) uCtl (
    .clk       (clk),
    .rst       (rst),
    .tuningWord(tuningWord),
    .romAddr   (romAddr),
    .strobe    (ctlStrobe)
  );

  sine_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rst      (rst),
    .negMode  (negMode),
    .romAddr  (romAddr),
    .strobe   (ctlStrobe),
    .sample   (sample),
    .cycleSync(cycleSync)
  );
endmodule

// File: rtl/sine_quarter_gen_checker.sv
module sine_quarter_gen_checker #(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic [PHASE_W-1:0]       tuningWord,
  input logic                     negMode,
  input logic signed [DATA_W-1:0] sample,
  input logic                     cycleSync,
  input logic                     phaseNeg
);
  // Counts clocks with zero tuning word and unchanged mode.
  logic [2:0] quietCnt;
  logic       prevMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      quietCnt <= '0;
      prevMode <= negMode;
    end else begin
      prevMode <= negMode;
      if (tuningWord != '0 || negMode != prevMode) quietCnt <= '0;
      else if (quietCnt != 3'd7)                    quietCnt <= quietCnt + 3'd1;
    end
  end

  // R9: outputs cleared after a reset edge
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sample == '0 && !cycleSync));

  // R4: positive-half phase gives a non-negative sample three clocks on
  a_r4_positive_half: assert property (@(posedge clk) disable iff (rst)
    !$past(phaseNeg, 3) |-> !sample[DATA_W-1]);

  // R5: negation mode never yields -1
  a_r5_no_minus_one: assert property (@(posedge clk) disable iff (rst)
    $past(negMode, 2) |-> sample != {DATA_W{1'b1}});

  // R5: negation mode never reaches the most negative code
  a_r5_no_min_code: assert property (@(posedge clk) disable iff (rst)
    $past(negMode, 2) |-> sample != {1'b1, {(DATA_W-1){1'b0}}});

  // R10: zero tuning word freezes the output
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (quietCnt >= 3'd6) |-> $stable(sample));
endmodule

bind sine_quarter_gen sine_quarter_gen_checker #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .tuningWord(tuningWord),
  .negMode   (negMode),
  .sample    (sample),
  .cycleSync (cycleSync),
  .phaseNeg  (ctlStrobe.negate)
);

// File: tb/sine_quarter_gen_test.sv
module sine_quarter_gen_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [31:0]        tuningWord = '0;
  logic               negMode = 1'b1;
  logic signed [13:0] sample;
  logic               cycleSync;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  sine_quarter_gen uut (
    .clk       (clk),
    .rst       (rst),
    .tuningWord(tuningWord),
    .negMode   (negMode),
    .sample    (sample),
    .cycleSync (cycleSync)
  );

  // Expected-value model built from R1..R8.
  logic [31:0] mAcc = '0;
  bit mWrap = 0;
  int s1Mag = 0;  bit s1Neg = 0;  bit s1Sync = 0;
  int s2Val = 0;  bit s2Sync = 0; bit s2NegZero = 0;
  int outExp = 0; bit syncExp = 0; bit outNegZero = 0;

  function automatic int magOf(input int addr);
    return $rtoi(8191.0 * $sin(3.14159265358979323846 * real'(addr) / 4096.0) + 0.5);
  endfunction

  function automatic int lookMag(input logic [31:0] ph);
    int idx;
    idx = int'(ph[29:19]);
    return ph[30] ? magOf(2047 - idx) : magOf(idx);
  endfunction

  task automatic report(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic edgeRst, edgeMode;
    logic [31:0] edgeTw;
    logic [32:0] sum;
    @(posedge clk);
    edgeRst = rst; edgeMode = negMode; edgeTw = tuningWord;
    #1;
    if (edgeRst) begin
      mAcc = '0; mWrap = 0; s1Mag = 0; s1Neg = 0; s1Sync = 0;
      s2Val = 0; s2Sync = 0; s2NegZero = 0; outExp = 0; syncExp = 0; outNegZero = 0;
    end else begin
      outExp = s2Val; syncExp = s2Sync; outNegZero = s2NegZero;
      s2Val = s1Neg ? (edgeMode ? -s1Mag : -s1Mag - 1) : s1Mag;
      s2Sync = s1Sync; s2NegZero = s1Neg && (s1Mag == 0);
      s1Mag = lookMag(mAcc); s1Neg = mAcc[31]; s1Sync = mWrap;
      sum = {1'b0, mAcc} + {1'b0, edgeTw};
      mAcc = sum[31:0]; mWrap = sum[32];
    end
  endtask

  task automatic compareNow(input string valTag);
    report(valTag, int'(sample), outExp);
    report("R8 sync alignment", int'(cycleSync), int'(syncExp));
  endtask

  task automatic applyReset();
    @(negedge clk); rst = 1'b1;
    tick(); tick();
    @(negedge clk); rst = 1'b0;
  endtask

  // R9: state during and right after reset
  task automatic testReset();
    rst = 1'b1; tuningWord = 32'h0100_0000;
    tick(); tick(); tick();
    report("R9 reset sample", int'(sample), 0);
    report("R9 reset sync", int'(cycleSync), 0);
  endtask

  // R7 R3 R4 R5 R8: hand-computed quarter-step sequence
  task automatic testLatency();
    int expVals[7] = '{0, 0, 0, 8191, 0, -8191, 0};
    int expSync[7] = '{0, 0, 0, 0, 0, 0, 1};
    negMode = 1'b1;
    applyReset();
    tuningWord = 32'h4000_0000;
    for (int i = 0; i < 7; i++) begin
      tick();
      report("R7 R9 quarter-step value", int'(sample), expVals[i]);
      report("R8 quarter-step sync", int'(cycleSync), expSync[i]);
    end
  endtask

  // R2 R3 R4 R5 R6 R8: one full cycle at one table step per clock
  task automatic testFullCycle(input bit m);
    int maxOut = -100000, minOut = 100000, syncSeen = 0, negZeroSeen = 0;
    applyReset();
    negMode = m; tuningWord = 32'h0008_0000;
    for (int i = 0; i < 8200; i++) begin
      tick();
      if (outNegZero) begin
        negZeroSeen++;
        if (m) report("R5 zero crossing", int'(sample), 0);
        else   report("R6 zero crossing", int'(sample), -1);
      end
      compareNow(m ? "R3 R4 R5 waveform" : "R3 R4 R6 waveform");
      if (int'(sample) > maxOut) maxOut = int'(sample);
      if (int'(sample) < minOut) minOut = int'(sample);
      if (cycleSync) syncSeen++;
    end
    report("R2 peak", maxOut, 8191);
    report(m ? "R2 R5 trough" : "R2 R6 trough", minOut, m ? -8191 : -8192);
    report("R8 one sync per cycle", syncSeen, 1);
    report(m ? "R5 negative zero seen" : "R6 negative zero seen", int'(negZeroSeen > 0), 1);
  endtask

  // R1 R7: odd tuning words, mode changes mid-stream, back-to-back wraps
  task automatic testFastWords();
    applyReset();
    tuningWord = 32'h0765_4321; negMode = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 700 == 699) begin @(negedge clk); negMode = ~negMode; end
      tick();
      compareNow("R1 R7 odd tuning word");
    end
    @(negedge clk); tuningWord = 32'hF000_0000;
    for (int i = 0; i < 60; i++) begin
      tick();
      compareNow("R1 R8 large tuning word");
    end
  endtask

  // R10: zero tuning word holds the output
  task automatic testHold();
    int held;
    applyReset();
    tuningWord = 32'h0345_6789; negMode = 1'b0;
    for (int i = 0; i < 300; i++) tick();
    @(negedge clk); tuningWord = '0;
    for (int i = 0; i < 6; i++) tick();
    held = int'(sample);
    for (int i = 0; i < 20; i++) begin
      tick();
      report("R10 hold constant", int'(sample), held);
      compareNow("R10 hold value");
    end
  endtask

  // R9: reset in the middle of a run, then restart
  task automatic testMidReset();
    applyReset();
    tuningWord = 32'h0123_4567; negMode = 1'b1;
    for (int i = 0; i < 900; i++) tick();
    @(negedge clk); rst = 1'b1;
    tick();
    report("R9 mid-run reset sample", int'(sample), 0);
    report("R9 mid-run reset sync", int'(cycleSync), 0);
    tick();
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick();
      compareNow("R9 restart stream");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testLatency();
    testFullCycle(1'b1);
    testFullCycle(1'b0);
    testFastWords();
    testHold();
    testMidReset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule